// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Three-Way Compare

A purely combinational 32-bit integer unit. It takes two operands and a 4-bit operation select and returns one 32-bit result. The supported operations are a wrapping add, a multiply that keeps the low product word, a three-way magnitude compare, the bitwise AND, OR, XOR and NOT, and left, logical-right and arithmetic-right shifts. A separate mode input selects signed or unsigned magnitude, and only the compare uses it.

The block sits in an execute stage. The caller decodes an instruction into an operation select, presents both operands, and takes the result in the same cycle. The compare does not return a single boolean. It returns a small one-hot code, so one operation serves every relational test and the consumer picks out the bit it needs.

Top module: `int_alu`

## Requirements
- R1: Select 4'b0000 returns the sum of the operands, modulo 2^32 (a carry out of bit 31 is discarded).
- R2: Select 4'b0001 returns the low 32 bits of the product of the operands.
- R3: Select 4'b0010 returns a compare code. Bit 0 is set when a < b, bit 1 when a == b, and bit 2 when a > b. Exactly one of these bits is set, and bits 31..3 are zero. With the mode input at 0, both operands are compared as unsigned values.
- R4: With the mode input at 1, the compare treats both operands as two's-complement signed values.
- R5: Selects 4'b0011, 4'b0100 and 4'b0101 return the bitwise AND, OR and XOR of the operands.
- R6: Select 4'b0110 returns the bitwise complement of a, and operand b has no effect on the result.
- R7: Select 4'b0111 shifts a left by b[4:0] and fills with zeros. Bits 31..5 of b are ignored.
- R8: Select 4'b1000 shifts a right by b[4:0] and fills with zeros.
- R9: Select 4'b1001 shifts a right by b[4:0] and fills with copies of a[31].
- R10: The mode input has no effect on the result of any select other than 4'b0010.
- R11: Selects 4'b1010 through 4'b1111 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; the only operand used by NOT and the value that is shifted |
| opnd_b | input | 32 | Second operand; its low 5 bits give the shift distance |
| op_sel | input | 4 | Operation select |
| signed_mode | input | 1 | 1 = signed compare, 0 = unsigned compare |
| result | output | 32 | Result of the selected operation |

## Verification
The stimulus mixes hand-picked boundary operands with pseudo-random pairs, and every result is compared against a reference model in the bench. The compare is driven with pairs whose most significant bits differ, for example 0x80000000 against 1. Those pairs split signed from unsigned ordering, because the two modes must give opposite codes. The shifts are given distances of 0 and 31, and distances with upper bits set in b. These cases show whether only b[4:0] counts, and whether the arithmetic shift fills with sign bits while the logical shift fills with zeros. The same vectors are run again with the mode input flipped, and NOT is run with varied b, to show that neither input leaks into results where it should have no effect.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_MUL = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_NOT = 4'd6,
        OP_SLL = 4'd7,
        OP_SRL = 4'd8,
        OP_SRA = 4'd9
    } alu_op_e;

    // Packed order fixes the code positions: lt at bit 0, eq at bit 1, gt at bit 2.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_rel_t;

    localparam int CMP_W = $bits(cmp_rel_t);

endpackage

// File: rtl/int_alu_arith.sv
module int_alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] prod
);
    // Both outputs are W bits wide, so the carry and the upper product half fall away.
    assign sum  = a + b;
    assign prod = a * b;

endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    output cmp_rel_t     rel
);
    // Flipping the sign bit in both operands turns a signed compare into an
    // unsigned one, so a single magnitude comparator serves both modes.
    logic [W-1:0] a_key;
    logic [W-1:0] b_key;

    assign a_key = {a[W-1] ^ is_signed, a[W-2:0]};
    assign b_key = {b[W-1] ^ is_signed, b[W-2:0]};

    always_comb begin
        rel.lt = (a_key < b_key);
        rel.eq = (a == b);
        rel.gt = ~rel.lt & ~rel.eq;
    end

    always_comb begin
        assert_cmp_onehot_R3: assert ($onehot(rel))
            else $error("compare code is not one-hot");
    end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] not_o
);
    assign and_o = a & b;
    assign or_o  = a | b;
    assign xor_o = a ^ b;
    assign not_o = ~a;

    always_comb begin
        assert_xor_consistent_R5: assert (xor_o == (or_o & ~and_o))
            else $error("xor disagrees with and/or");
    end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   sll_o,
    output logic [W-1:0]   srl_o,
    output logic [W-1:0]   sra_o
);
    // Logarithmic shifter: stage s moves the word by 2**s when shamt[s] is set.
    logic [W-1:0] l_st [SHW+1];
    logic [W-1:0] r_st [SHW+1];
    logic [W-1:0] s_st [SHW+1];

    assign l_st[0] = a;
    assign r_st[0] = a;
    assign s_st[0] = a;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign l_st[s+1] = shamt[s] ? {l_st[s][W-1-D:0], {D{1'b0}}} : l_st[s];
        assign r_st[s+1] = shamt[s] ? {{D{1'b0}}, r_st[s][W-1:D]}   : r_st[s];
        assign s_st[s+1] = shamt[s] ? {{D{a[W-1]}}, s_st[s][W-1:D]} : s_st[s];
    end

    assign sll_o = l_st[SHW];
    assign srl_o = r_st[SHW];
    assign sra_o = s_st[SHW];

    always_comb begin
        if (!a[W-1]) begin
            assert_sra_pos_eq_srl_R9: assert (sra_o == srl_o)
                else $error("arithmetic shift of non-negative value differs from logical");
        end
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int OPW  = OP_W
) (
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [OPW-1:0] op_sel,
    input  logic           signed_mode,
    output logic [W-1:0]   result
);
    localparam int SHAMT_W = $clog2(W);

    logic [W-1:0] sum_w, prod_w;
    logic [W-1:0] and_w, or_w, xor_w, not_w;
    logic [W-1:0] sll_w, srl_w, sra_w;
    cmp_rel_t     rel_w;

    int_alu_arith #(.W(W)) u_arith (
        .a(opnd_a), .b(opnd_b), .sum(sum_w), .prod(prod_w)
    );

    int_alu_cmp #(.W(W)) u_cmp (
        .a(opnd_a), .b(opnd_b), .is_signed(signed_mode), .rel(rel_w)
    );

    int_alu_logic #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .and_o(and_w), .or_o(or_w), .xor_o(xor_w), .not_o(not_w)
    );

    int_alu_shift #(.W(W), .SHW(SHAMT_W)) u_shift (
        .a(opnd_a), .shamt(opnd_b[SHAMT_W-1:0]),
        .sll_o(sll_w), .srl_o(srl_w), .sra_o(sra_w)
    );

    always_comb begin
        case (alu_op_e'(op_sel))
            OP_ADD:  result = sum_w;
            OP_MUL:  result = prod_w;
            OP_CMP:  result = {{(W-CMP_W){1'b0}}, rel_w};
            OP_AND:  result = and_w;
            OP_OR:   result = or_w;
            OP_XOR:  result = xor_w;
            OP_NOT:  result = not_w;
            OP_SLL:  result = sll_w;
            OP_SRL:  result = srl_w;
            OP_SRA:  result = sra_w;
            default: result = '0;
        endcase
    end

    always_comb begin
        if (op_sel == OP_ADD) begin
            assert_add_inverse_R1: assert ((result - opnd_b) == opnd_a)
                else $error("sum minus b does not give a");
        end
        if (op_sel == OP_CMP) begin
            assert_cmp_upper_zero_R3: assert (result[W-1:CMP_W] == '0)
                else $error("compare result has upper bits set");
        end
        if (op_sel == OP_NOT) begin
            assert_not_complement_R6: assert ((result ^ opnd_a) == '1)
                else $error("NOT result is not the complement of a");
        end
    end

endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [3:0]  op_in = '0;
    logic        sm_in = 1'b0;
    logic [31:0] res_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu dut_i (
        .opnd_a(a_in), .opnd_b(b_in), .op_sel(op_in),
        .signed_mode(sm_in), .result(res_out)
    );

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                          logic [3:0] op, logic sm);
        logic [63:0] full;
        logic        less;
        int          sh;
        sh = int'(b % 32);
        case (op)
            4'd0: model = a + b;
            4'd1: begin full = {32'd0, a} * {32'd0, b}; model = full[31:0]; end
            4'd2: begin
                less = sm ? ($signed(a) < $signed(b)) : (a < b);
                if (a == b)  model = 32'd2;
                else if (less) model = 32'd1;
                else         model = 32'd4;
            end
            4'd3: model = a & b;
            4'd4: model = a | b;
            4'd5: model = a ^ b;
            4'd6: model = ~a;
            4'd7: model = a << sh;
            4'd8: model = a >> sh;
            4'd9: model = 32'($signed(a) >>> sh);
            default: model = 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic drive_check(input logic [31:0] a, input logic [31:0] b,
                               input logic [3:0] op, input logic sm,
                               input logic [31:0] exp, input string req);
        @(negedge clk);
        a_in = a; b_in = b; op_in = op; sm_in = sm;
        #1;
        n_checks++;
        if (res_out !== exp) begin
            n_fails++;
            $display("FAIL %s op=%b a=%h b=%h sm=%b: actual %h expected %h",
                     req, op, a, b, sm, res_out, exp);
        end
    endtask

    task automatic model_check(input logic [31:0] a, input logic [31:0] b,
                               input logic [3:0] op, input logic sm, input string req);
        drive_check(a, b, op, sm, model(a, b, op, sm), req);
    endtask

    task automatic t_reset;
        drive_check('0, '0, 4'd0, 1'b0, 32'd0, "R1 idle");
    endtask

    task automatic t_add;   // R1
        drive_check(32'hFFFF_FFFF, 32'd1, 4'd0, 1'b0, 32'd0, "R1");
        drive_check(32'h7FFF_FFFF, 32'd1, 4'd0, 1'b0, 32'h8000_0000, "R1");
        for (int i = 0; i < 40; i++) begin
            lfsr = next_rand(lfsr); a_in = lfsr;
            lfsr = next_rand(lfsr);
            model_check(a_in, lfsr, 4'd0, 1'b0, "R1");
        end
    endtask

    task automatic t_mul;   // R2
        drive_check(32'h0001_0000, 32'h0001_0000, 4'd1, 1'b0, 32'd0, "R2");
        drive_check(32'hFFFF_FFFF, 32'd2, 4'd1, 1'b0, 32'hFFFF_FFFE, "R2");
        drive_check(32'd12345, 32'd1000, 4'd1, 1'b0, 32'd12345000, "R2");
        for (int i = 0; i < 40; i++) begin
            lfsr = next_rand(lfsr); a_in = lfsr;
            lfsr = next_rand(lfsr);
            model_check(a_in, lfsr, 4'd1, 1'b0, "R2");
        end
    endtask

    task automatic t_cmp;   // R3, R4
        drive_check(32'h8000_0000, 32'd1, 4'd2, 1'b0, 32'd4, "R3");
        drive_check(32'h8000_0000, 32'd1, 4'd2, 1'b1, 32'd1, "R4");
        drive_check(32'hFFFF_FFFF, 32'd0, 4'd2, 1'b0, 32'd4, "R3");
        drive_check(32'hFFFF_FFFF, 32'd0, 4'd2, 1'b1, 32'd1, "R4");
        drive_check(32'h7FFF_FFFF, 32'h8000_0000, 4'd2, 1'b1, 32'd4, "R4");
        drive_check(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd2, 1'b1, 32'd2, "R4");
        drive_check(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd2, 1'b0, 32'd2, "R3");
        drive_check(32'd3, 32'd9, 4'd2, 1'b0, 32'd1, "R3");
        for (int i = 0; i < 40; i++) begin
            lfsr = next_rand(lfsr); a_in = lfsr;
            lfsr = next_rand(lfsr);
            model_check(a_in, lfsr, 4'd2, 1'b0, "R3");
            model_check(a_in, lfsr, 4'd2, 1'b1, "R4");
        end
    endtask

    task automatic t_logic; // R5
        drive_check(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd3, 1'b0, 32'hF000_F000, "R5");
        drive_check(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd4, 1'b0, 32'hFFF0_FFF0, "R5");
        drive_check(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd5, 1'b0, 32'h0FF0_0FF0, "R5");
        for (int i = 0; i < 20; i++) begin
            lfsr = next_rand(lfsr); a_in = lfsr;
            lfsr = next_rand(lfsr);
            for (int op = 3; op <= 5; op++) model_check(a_in, lfsr, 4'(op), 1'b0, "R5");
        end
    endtask

    task automatic t_not;   // R6
        drive_check(32'h1234_5678, 32'd0, 4'd6, 1'b0, 32'hEDCB_A987, "R6");
        drive_check(32'h1234_5678, 32'hFFFF_FFFF, 4'd6, 1'b0, 32'hEDCB_A987, "R6");
        drive_check(32'h1234_5678, 32'hA5A5_5A5A, 4'd6, 1'b0, 32'hEDCB_A987, "R6");
    endtask

    task automatic t_shift; // R7, R8, R9
        drive_check(32'h0000_0001, 32'd31, 4'd7, 1'b0, 32'h8000_0000, "R7");
        drive_check(32'h0000_0001, 32'd33, 4'd7, 1'b0, 32'h0000_0002, "R7");
        drive_check(32'hABCD_1234, 32'hFFFF_FFE0, 4'd7, 1'b0, 32'hABCD_1234, "R7");
        drive_check(32'h8000_0000, 32'd31, 4'd8, 1'b0, 32'h0000_0001, "R8");
        drive_check(32'h8000_0000, 32'd33, 4'd8, 1'b0, 32'h4000_0000, "R8");
        drive_check(32'h8000_0000, 32'd31, 4'd9, 1'b0, 32'hFFFF_FFFF, "R9");
        drive_check(32'h8000_0000, 32'd4, 4'd9, 1'b0, 32'hF800_0000, "R9");
        drive_check(32'h4000_0000, 32'd4, 4'd9, 1'b0, 32'h0400_0000, "R9");
        drive_check(32'hF000_0000, 32'h20, 4'd9, 1'b0, 32'hF000_0000, "R9");
        for (int s = 0; s < 32; s++) begin
            lfsr = next_rand(lfsr);
            model_check(lfsr, 32'(s), 4'd7, 1'b0, "R7");
            model_check(lfsr, 32'(s), 4'd8, 1'b0, "R8");
            model_check(lfsr | 32'h8000_0000, 32'(s), 4'd9, 1'b0, "R9");
        end
    endtask

    task automatic t_mode_ignored; // R10
        for (int op = 0; op < 16; op++) begin
            if (op != 2) begin
                model_check(32'h8000_0003, 32'hFFFF_FFF5, 4'(op), 1'b1, "R10");
                model_check(32'h8000_0003, 32'hFFFF_FFF5, 4'(op), 1'b0, "R10");
            end
        end
    endtask

    task automatic t_unused; // R11
        for (int op = 10; op < 16; op++) begin
            drive_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(op), 1'b0, 32'd0, "R11");
            drive_check(32'h1234_5678, 32'h9ABC_DEF0, 4'(op), 1'b1, 32'd0, "R11");
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_mul();
        t_cmp();
        t_logic();
        t_not();
        t_shift();
        t_mode_ignored();
        t_unused();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule